// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel PCM stream from a serial data line, with a bit clock and a channel-select (word) clock, and turns it into parallel samples. All three serial inputs are brought into the system clock domain through a synchroniser chain. Every rising bit-clock edge then counts as one bit event. Three framings are handled: I2S, left-justified and right-justified. Each can carry 16, 18, 20 or 24-bit words. The bit clock may run at 32, 48 or 64 times the frame rate. No ratio setting is needed, because the block measures each half-frame between channel-select edges. Bit positions that do not belong to the configured word are discarded. Each word is left-aligned into a 24-bit output, and the low bits below the word are filled with zeros.

Format and word length are static control inputs. Change them only while reset is held. Once a frame is complete (a left word followed by a right word), both samples appear together on the outputs and a single-cycle valid pulse is raised.

Control is a five-state machine:
- `ST_IDLE` waits for the first bit event after reset and primes the edge history. Transition *prime* leads to `ST_HUNT`.
- `ST_HUNT` discards the partial half-frame in progress. On the first half-frame boundary, transition *lock_left* goes to `ST_LEFT` and transition *lock_right* goes to `ST_WAIT_L`.
- `ST_WAIT_L` is a right half-frame with no left word held. Transition *skip* goes to `ST_LEFT` and raises no valid pulse.
- `ST_LEFT` captures the left word. Transition *hold_left* stores it and goes to `ST_RIGHT`.
- `ST_RIGHT` captures the right word. Transition *emit* presents both words, pulses valid and returns to `ST_LEFT`.

Top module: `serial_audio_rx`

## Requirements
- R1: I2S framing (fmt code 0): channel-select low carries the left word and high carries the right word. The word's MSB is the bit sampled on the second rising bit-clock edge after a channel-select change.
- R2: Left-justified framing (fmt code 1): the MSB is the bit sampled on the first rising bit-clock edge after a channel-select change. Channel-select high carries the left word. Code 3 behaves the same way.
- R3: Right-justified framing (fmt code 2): the word occupies the last N bits of the half-frame, where N is the configured word length, and its LSB is on the final bit-clock edge. Channel-select high carries the left word.
- R4: In I2S and left-justified framing, every bit of a half-frame after the first N word bits is ignored. In right-justified framing, every bit before the last N is ignored.
- R5: Word length code (wlen) selects N: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24 bits.
- R6: The output word has the received MSB at bit 23, and bits below 24-N are zero.
- R7: After the right word of a frame completes, valid rises for exactly one system clock. In that cycle the left and right outputs both hold that frame's words, and they stay unchanged until the next pulse.
- R8: Bit clocks of 32, 48 and 64 edges per frame work without any ratio setting. The half-frame length is taken from the channel-select edges.
- R9: After reset both outputs are zero and valid is low. No valid pulse occurs until one complete left half-frame and the following right half-frame have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 4x faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| sclk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrclk_i | input | 1 | Channel-select (word) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| wlen_i | input | 2 | Word length code: 0/1/2/3 = 16/18/20/24 bits |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle pulse when a new frame is presented |

## Verification
The bench builds the block with its default parameters: a 24-bit output word, a two-stage synchroniser and half-frames of up to 32 bits. With these values every one of the three bit-clock ratios can be reached. The bench drives seven combinations of framing, word length and ratio. These include a 24-bit I2S word that fills a 48-edge frame completely, so its LSB spills into the next half-frame's first slot. Every unused slot carries random bits, which exercises the masking on both sides of the word. A lead-in half-frame before each run and a lead-out half-frame after it check that the first frame is captured and the last one is flushed.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_ALT = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_WAIT_L,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

    function automatic logic [4:0] word_bits(input logic [1:0] code);
        logic [4:0] n;
        unique case (code)
            2'd0:    n = 5'd16;
            2'd1:    n = 5'd18;
            2'd2:    n = 5'd20;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         rise0_o
);
    logic [W-1:0] pipe [STAGES];
    logic         last0;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      pipe[g] <= '0;
                else if (g == 0) pipe[g] <= async_i;
                else             pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last0 <= 1'b0;
        else        last0 <= pipe[STAGES-1][0];
    end

    assign sync_o  = pipe[STAGES-1];
    assign rise0_o = pipe[STAGES-1][0] & ~last0;

    // R8: bit events are isolated, never two in a row
    p_rise_spaced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise0_o |=> !rise0_o);

endmodule

// File: rtl/sarx_shifter.sv
module sarx_shifter #(
    parameter int OUT_W    = 24,
    parameter int MAX_HALF = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             start_i,
    input  logic             bit_i,
    input  logic             keep_all_i,
    input  logic [4:0]       wbits_i,
    output logic [OUT_W-1:0] aligned_o
);
    localparam int CNT_W = $clog2(MAX_HALF + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [OUT_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             room;

    assign room = keep_all_i || (cnt < CNT_W'(wbits_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (start_i) begin
            shreg <= {{(OUT_W-1){1'b0}}, bit_i};
            cnt   <= CNT_W'(1);
        end else if (step_i) begin
            if (room) shreg <= {shreg[OUT_W-2:0], bit_i};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    assign aligned_o = shreg << (OUT_W - int'(wbits_i));

    // R4: when capturing from the front, nothing past the word is kept
    p_lead_capture_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_all_i |-> ((shreg >> wbits_i) == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int OUT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_HALF    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             lrclk_i,
    input  logic             sdata_i,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       wlen_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    import sarx_pkg::*;

    rx_state_e        state, state_nx;
    logic [2:0]       sync_v;
    logic             rise, lr_s, dat_s;
    logic             lr_prev, eff_prev, eff, bnd, new_left;
    logic             i2s_mode, rj_mode;
    logic [4:0]       wbits;
    logic [OUT_W-1:0] aligned, hold_l;

    sarx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, lrclk_i, sclk_i}),
        .sync_o  (sync_v),
        .rise0_o (rise)
    );
    assign lr_s  = sync_v[1];
    assign dat_s = sync_v[2];

    assign i2s_mode = (fmt_e'(fmt_i) == FMT_I2S);
    assign rj_mode  = (fmt_e'(fmt_i) == FMT_RJ);
    assign wbits    = word_bits(wlen_i);

    // I2S is handled as front-justified framing against a one-bit-late select
    assign eff      = i2s_mode ? lr_prev : lr_s;
    assign bnd      = rise && (state != ST_IDLE) && (eff != eff_prev);
    assign new_left = i2s_mode ? ~eff : eff;

    sarx_shifter #(.OUT_W(OUT_W), .MAX_HALF(MAX_HALF)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (rise && (state != ST_IDLE)),
        .start_i    (bnd),
        .bit_i      (dat_s),
        .keep_all_i (rj_mode),
        .wbits_i    (wbits),
        .aligned_o  (aligned)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (rise) state_nx = ST_HUNT;
            ST_HUNT:   if (bnd)  state_nx = new_left ? ST_LEFT : ST_WAIT_L;
            ST_WAIT_L: if (bnd)  state_nx = ST_LEFT;
            ST_LEFT:   if (bnd)  state_nx = ST_RIGHT;
            ST_RIGHT:  if (bnd)  state_nx = ST_LEFT;
            default:             state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev  <= 1'b0;
            eff_prev <= 1'b0;
            hold_l   <= '0;
            left_o   <= '0;
            right_o  <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (rise) begin
                lr_prev  <= lr_s;
                eff_prev <= (state == ST_IDLE) ? lr_s : eff;
            end
            if (bnd) begin
                unique case (state)
                    ST_LEFT: hold_l <= aligned;
                    ST_RIGHT: begin
                        left_o  <= hold_l;
                        right_o <= aligned;
                        valid_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: valid is a single-cycle pulse
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: a pulse only follows a completed right half-frame
    p_valid_after_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state) == ST_RIGHT));

    // R6: zero fill below the word on both outputs
    p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (((left_o | right_o) << int'(wbits)) == '0));

    // R7: outputs are steady between pulses
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || ($stable(left_o) && $stable(right_o))));

endmodule

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [1:0]  fmt = 2'd0, wlen = 2'd0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R9";
    logic  carry = 1'b0;
    logic  prev_valid = 1'b0;
    logic [47:0] exp_q [$];

    always #2 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .lrclk_i(lrclk), .sdata_i(sdata),
        .fmt_i(fmt), .wlen_i(wlen), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    task automatic sbit(input logic lr, input logic d);
        @(negedge clk);
        lrclk = lr;
        sdata = d;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_half(input logic lr, input logic [23:0] v, input int w, input int n);
        logic slot [32];
        for (int p = 0; p < n; p++) begin
            if (fmt == 2'd2) slot[p] = (p >= n - w) ? v[n-1-p] : 1'($urandom % 2);
            else             slot[p] = (p < w)      ? v[w-1-p] : 1'($urandom % 2);
        end
        for (int p = 0; p < n; p++) begin
            if (fmt == 2'd0) sbit(lr, (p == 0) ? carry : slot[p-1]);
            else             sbit(lr, slot[p]);
        end
        carry = slot[n-1];
    endtask

    task automatic run_group(input logic [1:0] f, input logic [1:0] wc, input int n,
                             input string t);
        int w;
        logic left_lvl;
        logic [23:0] lv, rv;
        w = (wc == 0) ? 16 : (wc == 1) ? 18 : (wc == 2) ? 20 : 24;
        left_lvl = (f == 2'd0) ? 1'b0 : 1'b1;
        rst_n = 1'b0;
        fmt = f;
        wlen = wc;
        sclk = 1'b0;
        lrclk = ~left_lvl;
        carry = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (left_o !== 24'd0 || right_o !== 24'd0 || valid_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R9 reset state: left=%h right=%h valid=%b expected 0 0 0",
                     left_o, right_o, valid_o);
        end
        tag = t;
        send_half(~left_lvl, 24'($urandom), w, n);
        for (int k = 0; k < 3; k++) begin
            lv = 24'($urandom) & 24'((1 << w) - 1);
            rv = 24'($urandom) & 24'((1 << w) - 1);
            exp_q.push_back({24'(lv << (24 - w)), 24'(rv << (24 - w))});
            send_half(left_lvl, lv, w, n);
            send_half(~left_lvl, rv, w, n);
        end
        send_half(left_lvl, 24'($urandom), w, n);
        repeat (20) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R7 %s: %0d frames without valid, expected 0", t, exp_q.size());
            exp_q.delete();
        end
    endtask

    // cycle-by-cycle monitor of the valid strobe against the expected frame queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o && prev_valid) begin
                n_checks++;
                n_errors++;
                $display("FAIL R7 valid high two cycles: actual 1 expected 0");
            end
            if (valid_o) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_errors++;
                    $display("FAIL R9 unexpected valid: left=%h right=%h expected none",
                             left_o, right_o);
                end else begin
                    logic [47:0] e;
                    e = exp_q.pop_front();
                    if ({left_o, right_o} !== e) begin
                        n_errors++;
                        $display("FAIL %s frame: actual %h/%h expected %h/%h",
                                 tag, left_o, right_o, e[47:24], e[23:0]);
                    end
                end
            end
        end
        prev_valid = rst_n && valid_o;
    end

    initial begin
        run_group(2'd0, 2'd3, 32, "R1/R5/R6/R8 i2s w24 64fs");
        run_group(2'd0, 2'd3, 24, "R1/R4/R8 i2s w24 48fs full slot");
        run_group(2'd0, 2'd0, 16, "R1/R5 i2s w16 32fs");
        run_group(2'd1, 2'd2, 32, "R2/R4/R6 lj w20 64fs");
        run_group(2'd1, 2'd0, 24, "R2/R4/R8 lj w16 48fs");
        run_group(2'd2, 2'd1, 32, "R3/R4/R6 rj w18 64fs");
        run_group(2'd2, 2'd3, 24, "R3/R5/R8 rj w24 48fs");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule